// File: doc/BRIEF.md
# Reset Button Pulse Generator

This block turns an active-low reset push-button into a single reset request of fixed length. Software chooses the kind of reset in advance: a warm reset of the host partition only, or a full power-cycle reset. The block latches that choice when it fires and keeps it on a flag beside the request. A platform sequencer downstream carries out the reset itself.

The button is first brought into the clock domain. Two detection modes exist. With filtering off, the first falling edge fires the request. With filtering on, the button must stay pressed, without interruption, for a debounce interval before the request fires. Once fired, the request lasts a fixed number of timebase ticks, whatever the button does in the meantime. After that the block will not fire again until two things are true: the filtered button reads released, and the system reports that it is fully running with the platform reset inactive. All times are counted in strobes on a timebase tick input.

The controller has four states. IDLE waits for a press. QUALIFY waits for the filtered press. PULSE drives the request. WAIT_REARM blocks new requests. The transitions are:

- IDLE to PULSE on a falling edge with filtering off.
- IDLE to QUALIFY on a pressed level with filtering on.
- QUALIFY to PULSE when the filtered level reads pressed.
- QUALIFY to IDLE if the button is released first.
- PULSE to WAIT_REARM on the tick that completes the pulse.
- WAIT_REARM to IDLE once the re-arm conditions all hold.

Top module: `rstbtn_pulse_gen`

## Requirements
- R1: While and after reset, with no press, `rst_req` and `rst_is_full` are both 0.
- R2: With `dbnc_en`=0, a falling edge of `btn_n` raises `rst_req` on the third rising clock edge after the input changes.
- R3: With `dbnc_en`=1, `rst_req` rises only after `btn_n` has been held low for DEBOUNCE_TICKS consecutive ticks. A shorter press produces no request.
- R4: `rst_req` stays high for between PULSE_TICKS-1 and PULSE_TICKS tick periods. The default of 56 ticks of 100 us falls inside a 5 to 6 ms window. Releasing or holding the button has no effect on the width.
- R5: While `rst_req` is high, `rst_is_full` equals the value `pwrcyc_sel` had when the request fired. Here 1 means a full power cycle and 0 means a warm host reset. Changes of `pwrcyc_sel` during the pulse are ignored, and `rst_is_full` is 0 whenever `rst_req` is 0.
- R6: After a pulse, no new request fires while the filtered button still reads pressed. A button held through and past the pulse gives no second request.
- R7: After a pulse, no new request fires until `sys_running` and `plat_rst_inactive` are both 1. Presses made while either one is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe, one clock wide |
| btn_n | input | 1 | Raw reset button, low when pressed |
| dbnc_en | input | 1 | 1 selects filtered detection |
| pwrcyc_sel | input | 1 | 1 selects a full power-cycle reset |
| sys_running | input | 1 | System is in its full running state |
| plat_rst_inactive | input | 1 | Platform reset is deasserted |
| rst_req | output | 1 | Reset request pulse |
| rst_is_full | output | 1 | Request type: 1 full power cycle, 0 warm |

## Verification
In direct mode the request is due exactly three clock edges after the button falls: two synchronizer stages plus the state register. The bench drives inputs on falling edges and samples one time unit after each rising edge, so it counts precisely to that third edge. Debounced detection and pulse width depend on where the tick falls, so those results are checked against bounds in cycles derived from the tick period. The bounds are (DEBOUNCE_TICKS-1) to DEBOUNCE_TICKS periods plus the synchronizer latency, and PULSE_TICKS-1 to PULSE_TICKS periods for the width. Re-arm blocking is checked by pressing while a condition is missing and then watching the output for longer than a full debounce interval.

// File: rtl/rbp_pkg.sv
package rbp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_QUALIFY    = 2'd1,
        ST_PULSE      = 2'd2,
        ST_WAIT_REARM = 2'd3
    } rbp_state_e;
endpackage

// File: rtl/rbp_sync.sv
module rbp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/rbp_debounce.sv
module rbp_debounce #(
    parameter int DEBOUNCE_TICKS = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw_act,
    output logic db_act
);
    localparam int CW = $clog2(DEBOUNCE_TICKS + 1);

    logic [CW-1:0] cnt_q;
    logic          db_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            db_q  <= 1'b0;
        end else if (raw_act == db_q) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == CW'(DEBOUNCE_TICKS - 1)) begin
                cnt_q <= '0;
                db_q  <= raw_act;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign db_act = db_q;

    // R3: the filtered level only moves on a timebase strobe
    assert_db_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(db_q) |-> $past(tick));
endmodule

// File: rtl/rbp_pulse_timer.sv
module rbp_pulse_timer #(
    parameter int PULSE_TICKS = 56
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(PULSE_TICKS + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (!run)     cnt_q <= '0;
        else if (tick)     cnt_q <= (cnt_q == CW'(PULSE_TICKS - 1)) ? '0 : cnt_q + 1'b1;
    end

    assign done = run && tick && (cnt_q == CW'(PULSE_TICKS - 1));

    // R4: the tick count never passes the configured width
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(PULSE_TICKS));
endmodule

// File: rtl/rstbtn_pulse_gen.sv
module rstbtn_pulse_gen
    import rbp_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int DEBOUNCE_TICKS = 160,
    parameter int PULSE_TICKS    = 56
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic btn_n,
    input  logic dbnc_en,
    input  logic pwrcyc_sel,
    input  logic sys_running,
    input  logic plat_rst_inactive,
    output logic rst_req,
    output logic rst_is_full
);
    rbp_state_e state_q, state_d;
    logic       btn_n_s;
    logic       btn_prev_q;
    logic       press_lvl;
    logic       press_edge;
    logic       db_act;
    logic       pulse_done;
    logic       full_q;
    logic       fire;
    logic       rearm_ok;

    rbp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (btn_n),
        .d_out (btn_n_s)
    );

    assign press_lvl = ~btn_n_s;

    rbp_debounce #(.DEBOUNCE_TICKS(DEBOUNCE_TICKS)) u_debounce (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .raw_act (press_lvl),
        .db_act  (db_act)
    );

    rbp_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .run   (state_q == ST_PULSE),
        .done  (pulse_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) btn_prev_q <= 1'b1;
        else        btn_prev_q <= btn_n_s;
    end

    assign press_edge = btn_prev_q && !btn_n_s;
    assign rearm_ok   = !db_act && sys_running && plat_rst_inactive;

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!dbnc_en && press_edge) begin
                    state_d = ST_PULSE;
                    fire    = 1'b1;
                end else if (dbnc_en && press_lvl) begin
                    state_d = ST_QUALIFY;
                end
            end
            ST_QUALIFY: begin
                if (db_act) begin
                    state_d = ST_PULSE;
                    fire    = 1'b1;
                end else if (!press_lvl) begin
                    state_d = ST_IDLE;
                end
            end
            ST_PULSE: begin
                if (pulse_done) state_d = ST_WAIT_REARM;
            end
            ST_WAIT_REARM: begin
                if (rearm_ok) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            full_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (fire) full_q <= pwrcyc_sel;
        end
    end

    always_comb begin
        rst_req     = (state_q == ST_PULSE);
        rst_is_full = (state_q == ST_PULSE) && full_q;
    end

    // R5: the type flag is frozen while the request is up
    assert_type_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && $past(rst_req)) |-> (rst_is_full == $past(rst_is_full)));

    // R4: the request only drops on a timebase strobe
    assert_end_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> $past(tick));

    // R3: no request from QUALIFY without a filtered press
    assert_qualify_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_QUALIFY && !db_act) |=> !rst_req);

    // R6: a filtered press keeps the block blocked
    assert_rearm_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_REARM && db_act) |=> (state_q == ST_WAIT_REARM));

    // R7: system state must be complete before re-arming
    assert_rearm_sys_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_REARM && (!sys_running || !plat_rst_inactive))
        |=> (state_q == ST_WAIT_REARM));
endmodule

// File: tb/rstbtn_pulse_gen_bench.sv
module rstbtn_pulse_gen_bench;
    localparam int TP   = 4;
    localparam int DB   = 8;
    localparam int PT   = 56;
    localparam int TMIN = 50;
    localparam int TMAX = 60;

    // bits: [3] dbnc_en, [2] pwrcyc_sel, [1] flip sel mid-pulse, [0] release early
    localparam logic [3:0] VECS [0:3] = '{4'b0001, 4'b0110, 4'b1011, 4'b1100};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic btn_n = 1'b1;
    logic dbnc_en = 1'b0;
    logic pwrcyc_sel = 1'b0;
    logic sys_running = 1'b1;
    logic plat_rst_inactive = 1'b1;
    logic rst_req;
    logic rst_is_full;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    rstbtn_pulse_gen #(
        .SYNC_STAGES(2), .DEBOUNCE_TICKS(DB), .PULSE_TICKS(PT)
    ) u_rstbtn_pulse_gen (
        .clk(clk), .rst_n(rst_n), .tick(tick), .btn_n(btn_n),
        .dbnc_en(dbnc_en), .pwrcyc_sel(pwrcyc_sel), .sys_running(sys_running),
        .plat_rst_inactive(plat_rst_inactive), .rst_req(rst_req),
        .rst_is_full(rst_is_full)
    );

    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            tick = (tc == TP - 1);
            tc = (tc == TP - 1) ? 0 : tc + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(output int n);
        @(posedge clk); #1;
        n = 1;
    endtask

    // count edges until rst_req rises (returns limit+1 if never)
    task automatic wait_req(input int limit, output int c);
        int d;
        c = 0;
        while (c <= limit) begin
            step(d);
            c++;
            if (rst_req) break;
        end
    endtask

    task automatic quiet(input int cyc, input string req);
        int seen = 0;
        int d;
        for (int i = 0; i < cyc; i++) begin
            step(d);
            if (rst_req) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    task automatic run_vec(input logic [3:0] v);
        int c, w, bad, d;
        bit sel;
        sel = v[2];
        @(negedge clk);
        dbnc_en = v[3];
        pwrcyc_sel = sel;
        btn_n = 1'b0;
        wait_req(DB * TP + 20, c);
        if (!v[3])
            chk(c == 3, "R2 direct latency", c, 3);
        else
            chk(c >= (DB - 1) * TP && c <= DB * TP + 6, "R3 filtered latency", c, DB * TP);
        chk(rst_is_full == sel, "R5 type at fire", rst_is_full, sel);
        @(negedge clk);
        if (v[1]) pwrcyc_sel = ~sel;
        if (v[0]) btn_n = 1'b1;
        w = 1; bad = 0;
        forever begin
            step(d);
            if (!rst_req) break;
            w++;
            if (rst_is_full != sel) bad++;
        end
        chk(bad == 0, "R5 type held", bad, 0);
        chk(w >= (PT - 1) * TP + 1 && w <= PT * TP, "R4 width ticks", w, PT * TP);
        chk(w >= TMIN * TP && w <= TMAX * TP, "R4 width window", w, PT * TP);
        chk(rst_is_full == 1'b0, "R5 flag clear", rst_is_full, 0);
        if (!v[0]) quiet(40, "R6 held no retrigger");
        @(negedge clk);
        btn_n = 1'b1;
        pwrcyc_sel = sel;
        quiet((DB + 2) * TP + 10, "R6 release quiet");
    endtask

    initial begin
        int c;
        repeat (5) @(posedge clk);
        #1;
        chk(rst_req == 1'b0, "R1 req in reset", rst_req, 0);
        chk(rst_is_full == 1'b0, "R1 type in reset", rst_is_full, 0);
        @(negedge clk);
        rst_n = 1'b1;
        quiet(20, "R1 idle after reset");

        for (int i = 0; i < 4; i++) run_vec(VECS[i]);

        // R3: a short press in filtered mode is discarded
        @(negedge clk);
        dbnc_en = 1'b1;
        btn_n = 1'b0;
        repeat ((DB - 3) * TP) @(negedge clk);
        btn_n = 1'b1;
        quiet(DB * TP + 20, "R3 short press");

        // R7: blocked while the system is not running
        @(negedge clk);
        dbnc_en = 1'b0;
        pwrcyc_sel = 1'b1;
        btn_n = 1'b0;
        wait_req(10, c);
        chk(c == 3, "R2 direct fire", c, 3);
        @(negedge clk);
        btn_n = 1'b1;
        sys_running = 1'b0;
        wait (!rst_req);
        repeat ((DB + 2) * TP) @(negedge clk);
        btn_n = 1'b0;
        quiet(20, "R7 sys not running");
        @(negedge clk);
        btn_n = 1'b1;
        repeat ((DB + 2) * TP) @(negedge clk);
        sys_running = 1'b1;
        plat_rst_inactive = 1'b0;
        repeat (4) @(negedge clk);
        btn_n = 1'b0;
        quiet(20, "R7 platform reset active");
        @(negedge clk);
        btn_n = 1'b1;
        repeat ((DB + 2) * TP) @(negedge clk);
        plat_rst_inactive = 1'b1;
        repeat (4) @(negedge clk);
        pwrcyc_sel = 1'b0;
        btn_n = 1'b0;
        wait_req(10, c);
        chk(c == 3, "R7 re-armed fire", c, 3);
        chk(rst_is_full == 1'b0, "R5 warm type", rst_is_full, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule